// File: doc/BRIEF.md
# Fetch-Decode-Execute Control Sequencer

This block is a small processor control unit. It runs a stored program one instruction at a time. Each instruction passes through four phases in a fixed order: fetch, decode, execute and store. The block keeps a program counter, an instruction register, an operand latch, an 8-bit accumulator and a carry flag.

All traffic to program and data memory goes through a single request port. The port carries a request strobe, a write enable, an address and write data. Each request stays asserted and unchanged until memory answers with a one-cycle completion pulse.

The instruction word carries an opcode and a direct address. Load and add fetch their operand through a second memory read during decode. Store writes the accumulator during the store phase. Jump replaces the program counter. Halt parks the block until reset.

Top module: `fde_sequencer`

## Requirements
- R1: While reset is held (synchronous, active low), the program counter equals `start_addr`. The accumulator and carry are zero and `halted` is low. A read request (`mem_req`=1, `mem_we`=0) is presented at `start_addr`.
- R2: An instruction word is 8 bits wide. The opcode sits in bits [7:5] and the direct address in bits [4:0]. The opcode values are 000 load, 001 add, 010 store, 011 jump and 111 halt. Each instruction begins with a read at the program counter, and the returned word becomes the instruction.
- R3: The program counter advances by one, modulo 32, in the cycle the instruction read completes. The next fetch therefore reads the following address, and address 31 is followed by address 0.
- R4: Load (000) and add (001) perform a second read, at the instruction's address field, after the fetch and before any further request. No other opcode issues an operand read.
- R5: Load copies the operand into the accumulator.
- R6: Add sets the accumulator to (accumulator + operand) mod 256 and sets carry to the carry-out of that sum. No other opcode changes carry.
- R7: Store (010) issues a write (`mem_we`=1) to the instruction's address field, with `mem_wdata` equal to the accumulator. It is the only opcode that writes.
- R8: Jump (011) makes the next fetch read from the instruction's address field.
- R9: Halt (111) sets `halted`. `halted` stays high and `mem_req` stays low until reset.
- R10: A pending request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_done` is sampled high. Memory latency changes timing only, not results.
- R11: Opcodes 100, 101 and 110 are no-ops. They change neither accumulator nor carry, issue no operand read and no write, and execution continues at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | ADDR_W | Program counter value loaded during reset |
| mem_req | output | 1 | Memory request strobe, held until done |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Memory address of the request |
| mem_wdata | output | DATA_W | Write data (accumulator) |
| mem_done | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | DATA_W | Read data, valid while mem_done is high |
| pc | output | ADDR_W | Program counter |
| acc | output | DATA_W | Accumulator |
| carry | output | 1 | Carry-out of the last add |
| halted | output | 1 | Sticky halt indication |

## Verification
The bench builds the block with its default parameters. These are an 8-bit data word, a 5-bit address and a 3-bit opcode, so the whole 32-word memory can be modelled. With a 5-bit address, the program counter wrap from 31 to 0 is reached by a program started at address 30.

Memory latency is a bench variable set to 1, 2 and 3 cycles. This exposes the request-holding behaviour under back-to-back and stretched handshakes. The expected request trace of every program is queued in advance and compared, one transaction at a time, with the traffic on the port.

// File: rtl/fde_pkg.sv
package fde_pkg;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_STORE  = 3'd3,
        PH_HALT   = 3'd4
    } phase_e;

    localparam logic [2:0] OPC_LOAD  = 3'b000;
    localparam logic [2:0] OPC_ADD   = 3'b001;
    localparam logic [2:0] OPC_STORE = 3'b010;
    localparam logic [2:0] OPC_JUMP  = 3'b011;
    localparam logic [2:0] OPC_HALT  = 3'b111;

    typedef struct packed {
        logic load;
        logic add;
        logic store;
        logic jump;
        logic halt;
        logic needs_opnd;
    } dec_t;

endpackage

// File: rtl/fde_decoder.sv
module fde_decoder
    import fde_pkg::*;
#(
    parameter int OPC_W = 3
) (
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    always_comb begin
        dec = '0;
        case (opcode)
            OPC_LOAD:  begin dec.load  = 1'b1; dec.needs_opnd = 1'b1; end
            OPC_ADD:   begin dec.add   = 1'b1; dec.needs_opnd = 1'b1; end
            OPC_STORE: dec.store = 1'b1;
            OPC_JUMP:  dec.jump  = 1'b1;
            OPC_HALT:  dec.halt  = 1'b1;
            default:   dec = '0;
        endcase
    end

endmodule

// File: rtl/fde_alu.sv
module fde_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    logic [DATA_W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b};
        sum  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
    end

endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
    import fde_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int OPC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] alu_sum,
    input  logic              alu_cout,
    output logic [OPC_W-1:0]  ir_op,
    output logic [DATA_W-1:0] opnd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic              halted
);

    localparam int IW = OPC_W + ADDR_W;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] pc;
        logic [IW-1:0]     ir;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] acc;
        logic              carry;
    } st_t;

    st_t               st_d, st_q;
    logic [ADDR_W-1:0] ir_addr;

    assign ir_addr = st_q.ir[ADDR_W-1:0];

    always_comb begin
        st_d      = st_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = st_q.pc;
        mem_wdata = st_q.acc;
        case (st_q.phase)
            PH_FETCH: begin
                mem_req = 1'b1;
                if (mem_done) begin
                    st_d.ir    = mem_rdata[IW-1:0];
                    st_d.pc    = st_q.pc + 1'b1;
                    st_d.phase = PH_DECODE;
                end
            end
            PH_DECODE: begin
                if (dec.needs_opnd) begin
                    mem_req  = 1'b1;
                    mem_addr = ir_addr;
                    if (mem_done) begin
                        st_d.opnd  = mem_rdata;
                        st_d.phase = PH_EXEC;
                    end
                end else begin
                    st_d.phase = PH_EXEC;
                end
            end
            PH_EXEC: begin
                st_d.phase = PH_STORE;
                if (dec.load) st_d.acc = st_q.opnd;
                if (dec.add) begin
                    st_d.acc   = alu_sum;
                    st_d.carry = alu_cout;
                end
                if (dec.jump) st_d.pc = ir_addr;
                if (dec.halt) st_d.phase = PH_HALT;
            end
            PH_STORE: begin
                if (dec.store) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = ir_addr;
                    if (mem_done) st_d.phase = PH_FETCH;
                end else begin
                    st_d.phase = PH_FETCH;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_FETCH;
            st_q.pc    <= start_addr;
            st_q.ir    <= '0;
            st_q.opnd  <= '0;
            st_q.acc   <= '0;
            st_q.carry <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ir_op  = st_q.ir[IW-1:ADDR_W];
    assign opnd   = st_q.opnd;
    assign pc     = st_q.pc;
    assign acc    = st_q.acc;
    assign carry  = st_q.carry;
    assign halted = (st_q.phase == PH_HALT);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req); // R9
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FETCH && mem_done) |=> (pc == $past(pc) + 1'b1)); // R3
    AST_CARRY_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.phase == PH_EXEC && dec.add) |=> $stable(carry)); // R6
    AST_LOAD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && dec.load) |=> (acc == $past(opnd))); // R5

endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
    import fde_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int OPC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic              halted
);

    dec_t              dec;
    logic [OPC_W-1:0]  ir_op;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] alu_sum;
    logic              alu_cout;

    fde_decoder #(.OPC_W(OPC_W)) i_dec (
        .opcode (ir_op),
        .dec    (dec)
    );

    fde_alu #(.DATA_W(DATA_W)) i_alu (
        .a    (acc),
        .b    (opnd),
        .sum  (alu_sum),
        .cout (alu_cout)
    );

    fde_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .mem_done   (mem_done),
        .mem_rdata  (mem_rdata),
        .dec        (dec),
        .alu_sum    (alu_sum),
        .alu_cout   (alu_cout),
        .ir_op      (ir_op),
        .opnd       (opnd),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .pc         (pc),
        .acc        (acc),
        .carry      (carry),
        .halted     (halted)
    );

endmodule

// File: tb/test_fde_sequencer.sv
`timescale 1ns/1ps
module test_fde_sequencer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] start_addr = '0;
    logic       mem_req, mem_we;
    logic [4:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_done = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [4:0] pc;
    logic [7:0] acc;
    logic       carry, halted;

    logic [7:0] mem [32];
    int lat = 1;
    int wait_cnt = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        bit         we;
        logic [4:0] addr;
        logic [7:0] data;
        bit         c;
        string      req;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fde_sequencer i_fde_sequencer (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .pc(pc), .acc(acc), .carry(carry), .halted(halted)
    );

    // memory model with programmable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_done <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_req && !mem_done) begin
            if (wait_cnt + 1 >= lat) begin
                mem_done  <= 1'b1;
                wait_cnt  <= 0;
                mem_rdata <= mem[mem_addr];
                if (mem_we) mem[mem_addr] <= mem_wdata;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_done <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_rd(input logic [4:0] a, input string req);
        item_t it;
        it.we = 1'b0; it.addr = a; it.data = '0; it.c = 1'b0; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic push_wr(input logic [4:0] a, input logic [7:0] d, input bit c,
                           input string req);
        item_t it;
        it.we = 1'b1; it.addr = a; it.data = d; it.c = c; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: pops the scoreboard on every completed transaction
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected transaction addr", int'(mem_addr), 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(mem_we == it.we, it.req, "write enable", int'(mem_we), int'(it.we));
                check(mem_addr == it.addr, it.req, "address", int'(mem_addr), int'(it.addr));
                if (it.we) begin
                    check(mem_wdata == it.data, it.req, "write data", int'(mem_wdata), int'(it.data));
                    check(carry == it.c, it.req, "carry at store", int'(carry), int'(it.c));
                end
            end
        end
        if (rst_n && halted && mem_req)
            check(1'b0, "R9", "request after halt", 1, 0);
    end

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    endtask

    task automatic run_prog(input logic [4:0] sa, input int l,
                            input logic [7:0] e_acc, input bit e_c, input logic [4:0] e_pc);
        int t;
        rst_n = 1'b0;
        start_addr = sa;
        lat = l;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc == sa, "R1", "reset pc", int'(pc), int'(sa));
        check(acc == 8'h00 && carry == 1'b0, "R1", "reset acc/carry", int'({carry, acc}), 0);
        check(halted == 1'b0, "R1", "reset halted", int'(halted), 0);
        check(mem_req && !mem_we && mem_addr == sa, "R1", "reset request addr",
              int'(mem_addr), int'(sa));
        rst_n = 1'b1;
        t = 0;
        while (!halted && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(halted == 1'b1, "R9", "halt reached (watchdog)", int'(halted), 1);
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R9", "halt sticky", int'(halted), 1);
        check(exp_q.size() == 0, "R2", "pending expected transactions", exp_q.size(), 0);
        exp_q.delete();
        check(acc == e_acc, "R5", "final acc", int'(acc), int'(e_acc));
        check(carry == e_c, "R6", "final carry", int'(carry), int'(e_c));
        check(pc == e_pc, "R3", "final pc", int'(pc), int'(e_pc));
    endtask

    initial begin
        // Test A: load/add/store, no-op, jump, halt; latency 1
        clear_mem();
        mem[0] = 8'h14; mem[1] = 8'h35; mem[2] = 8'h56; mem[3] = 8'h37;
        mem[4] = 8'h58; mem[5] = 8'h80; mem[6] = 8'h59; mem[7] = 8'h6A;
        mem[8] = 8'h5A; mem[10] = 8'hE0;
        mem[20] = 8'h70; mem[21] = 8'h25; mem[23] = 8'h80;
        push_rd(0, "R2");  push_rd(20, "R4"); push_rd(1, "R3"); push_rd(21, "R4");
        push_rd(2, "R3");  push_wr(22, 8'h95, 1'b0, "R7");
        push_rd(3, "R3");  push_rd(23, "R4"); push_rd(4, "R3");
        push_wr(24, 8'h15, 1'b1, "R6");
        push_rd(5, "R3");  push_rd(6, "R11"); push_wr(25, 8'h15, 1'b1, "R11");
        push_rd(7, "R3");  push_rd(10, "R8");
        run_prog(5'd0, 1, 8'h15, 1'b1, 5'd11);

        // Test B: wrap of pc, no-op codes 101/110, latency 3
        clear_mem();
        mem[30] = 8'h05; mem[31] = 8'hA0; mem[0] = 8'hC0; mem[1] = 8'h46;
        mem[2] = 8'hE0; mem[5] = 8'hFF;
        push_rd(30, "R1"); push_rd(5, "R10"); push_rd(31, "R3"); push_rd(0, "R3");
        push_rd(1, "R11"); push_wr(6, 8'hFF, 1'b0, "R10"); push_rd(2, "R11");
        run_prog(5'd30, 3, 8'hFF, 1'b0, 5'd3);

        // Test C: carry set then cleared by add; latency 2
        clear_mem();
        mem[0] = 8'h08; mem[1] = 8'h29; mem[2] = 8'h4C; mem[3] = 8'h2A;
        mem[4] = 8'h4B; mem[5] = 8'hE0;
        mem[8] = 8'hFF; mem[9] = 8'h01; mem[10] = 8'h05;
        push_rd(0, "R2");  push_rd(8, "R5");  push_rd(1, "R3"); push_rd(9, "R6");
        push_rd(2, "R3");  push_wr(12, 8'h00, 1'b1, "R6");
        push_rd(3, "R3");  push_rd(10, "R6"); push_rd(4, "R3");
        push_wr(11, 8'h05, 1'b0, "R6");
        push_rd(5, "R9");
        run_prog(5'd0, 2, 8'h05, 1'b0, 5'd6);
        check(mem[12] == 8'h00 && mem[11] == 8'h05, "R7", "memory after stores",
              int'({mem[12], mem[11]}), 16'h0005);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule